// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block sits between a host bus and a byte-wide asynchronous SRAM array. It forwards the host's chip-enable, write-enable, output-enable, address and write data to the array, and it decides when the array's read data may drive the host bus. While the supply is healthy, the block is transparent and follows the usual SRAM truth table.

The supply state arrives as an asynchronous comparator flag. It is resynchronised inside the block. When the flag drops, an access that is already under way keeps its controls for a bounded grace window. After that the array is sealed: every control is held inactive, address and data toward the array are zeroed, and the host data bus is released. When the supply comes back, protection stays in force for a long recovery window before access resumes. The block also keeps a sticky flag that records whether good supply has ever been seen since reset, which is the point at which the backup source becomes connected.

Both windows are given in microseconds and are converted to clock ticks from the clock-frequency parameter.

Top module: `pfwp_ctrl`

## Requirements
- R1: In the normal state, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_addr` and `mem_wdata` equal the matching host inputs in the same cycle, and `wr_blocked` is 0.
- R2: `host_dq_oe` is 1 only when the array is reached, `host_ce_n`=0, `host_we_n`=1 and `host_oe_n`=0. While it is 1, `host_rdata` equals `mem_rdata`. While it is 0, `host_rdata` is all zeros.
- R3: A write strobe at the array (`mem_ce_n`=0 and `mem_we_n`=0) occurs only while the host holds both CE and WE low. The state of `host_oe_n` has no effect on it, and `host_dq_oe` is 0 during a write.
- R4: If host WE is already low in the first cycle in which host CE is sampled low, `host_dq_oe` stays 0 until CE is sampled high again, even when WE rises and OE is low. If CE falls before WE, reading resumes once WE rises.
- R5: `supply_ok_a` passes through two synchronising flops. A drop takes effect on the third rising clock edge after it arrives. If host CE is high on that edge, protection starts on that edge.
- R6: If host CE is low on that third edge, the cycle keeps access to the array until CE is sampled high. Protection then starts on the next edge, and `force_pulse` stays 0.
- R7: If CE is still low after GRACE_US microseconds of ticks (counted from the third edge), protection is forced. `force_pulse` is 1 for exactly one cycle, and `wr_blocked` is 1 in that same cycle.
- R8: While protected, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_addr` and `mem_wdata` are 0, `host_dq_oe` is 0 and `wr_blocked` is 1, whatever the host drives.
- R9: After the synchronised supply flag rises, protection lasts a further RECOV_US microseconds of ticks. The normal state returns on the (3+RECOV_T)th edge after the rise. A supply drop during recovery returns the block to protection, and the next rise restarts the full count.
- R10: `backup_armed` is 0 after reset. It becomes 1 on the third edge after good supply is first seen, and it stays 1 through later supply drops.
- R11: Out of reset, the block is protected (`wr_blocked`=1, controls inactive) until good supply is seen and the recovery window has elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_a | input | 1 | Asynchronous supply-good comparator flag |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data toward host (zero when not driven) |
| host_dq_oe | output | 1 | Host data bus drive enable (0 means high impedance) |
| mem_ce_n | output | 1 | Array chip enable |
| mem_we_n | output | 1 | Array write enable |
| mem_oe_n | output | 1 | Array output enable |
| mem_addr | output | AW | Array address |
| mem_wdata | output | DW | Array write data |
| mem_rdata | input | DW | Array read data |
| wr_blocked | output | 1 | Writes currently blocked |
| force_pulse | output | 1 | One-cycle pulse when the grace window expired |
| backup_armed | output | 1 | Sticky flag: good supply has been seen since reset |

## Verification
On every cycle the assertions check four things: a protected block keeps the array and the host bus quiet, an array write strobe is always backed by a host write overlap, the host bus is driven only for a proper read, and the armed flag never falls. They also check that a forced protection pulse lasts one cycle and coincides with blocking. Only the bench scenarios can show the exact edge counts: the synchroniser latency, the length of the grace and recovery windows, the restart of recovery after a short dip, and the rule that a cycle in which WE fell first stays in high impedance.

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl #(
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned GRACE_US = 100,
  parameter int unsigned RECOV_US = 80_000,
  parameter int unsigned AW       = 20,
  parameter int unsigned DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok_a,
  input  logic          host_ce_n,
  input  logic          host_we_n,
  input  logic          host_oe_n,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_dq_oe,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          wr_blocked,
  output logic          force_pulse,
  output logic          backup_armed
);

  localparam int unsigned TPU     = CLK_HZ / 1_000_000;
  localparam int unsigned GRACE_T = (TPU * GRACE_US > 0) ? TPU * GRACE_US : 1;
  localparam int unsigned RECOV_T = (TPU * RECOV_US > 0) ? TPU * RECOV_US : 1;
  localparam int unsigned MAX_T   = (GRACE_T > RECOV_T) ? GRACE_T : RECOV_T;
  localparam int unsigned CW      = $clog2(MAX_T + 1);

  typedef enum logic [1:0] {ST_NORMAL, ST_GRACE, ST_PROT, ST_RECOV} st_t;

  st_t            st_q, st_d;
  logic [CW-1:0]  cnt_q;
  logic           sync1_q, sync2_q;
  logic           ce_prev_q, we_first_q;
  logic           force_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= supply_ok_a;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    st_d    = st_q;
    force_d = 1'b0;
    unique case (st_q)
      ST_NORMAL: if (!sync2_q) st_d = host_ce_n ? ST_PROT : ST_GRACE;
      ST_GRACE: begin
        if (host_ce_n) st_d = ST_PROT;
        else if (cnt_q == CW'(GRACE_T - 1)) begin
          st_d    = ST_PROT;
          force_d = 1'b1;
        end
      end
      ST_PROT:  if (sync2_q) st_d = ST_RECOV;
      ST_RECOV: begin
        if (!sync2_q) st_d = ST_PROT;
        else if (cnt_q == CW'(RECOV_T - 1)) st_d = ST_NORMAL;
      end
      default:  st_d = ST_PROT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_PROT;
      cnt_q        <= '0;
      force_pulse  <= 1'b0;
      backup_armed <= 1'b0;
    end else begin
      st_q         <= st_d;
      cnt_q        <= (st_d != st_q) ? '0 : cnt_q + 1'b1;
      force_pulse  <= force_d;
      backup_armed <= backup_armed | sync2_q;
    end
  end

  logic pass, cyc_start, we_first;

  assign pass      = (st_q == ST_NORMAL) || (st_q == ST_GRACE);
  assign cyc_start = !host_ce_n && ce_prev_q;
  assign we_first  = cyc_start ? !host_we_n : we_first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev_q  <= 1'b1;
      we_first_q <= 1'b0;
    end else begin
      ce_prev_q  <= host_ce_n;
      we_first_q <= !host_ce_n && we_first;
    end
  end

  assign mem_ce_n   = pass ? host_ce_n  : 1'b1;
  assign mem_we_n   = pass ? host_we_n  : 1'b1;
  assign mem_oe_n   = pass ? host_oe_n  : 1'b1;
  assign mem_addr   = pass ? host_addr  : '0;
  assign mem_wdata  = pass ? host_wdata : '0;
  assign host_dq_oe = pass && !host_ce_n && host_we_n && !host_oe_n && !we_first;
  assign host_rdata = host_dq_oe ? mem_rdata : '0;
  assign wr_blocked = !pass;

endmodule

module pfwp_ctrl_chk #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_ce_n,
  input logic          host_we_n,
  input logic          host_oe_n,
  input logic          host_dq_oe,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [AW-1:0] mem_addr,
  input logic          wr_blocked,
  input logic          force_pulse,
  input logic          backup_armed
);
  AST_PROT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |-> (mem_ce_n && mem_we_n && mem_oe_n && !host_dq_oe && mem_addr == '0)); // R8
  AST_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_we_n) |-> (!host_ce_n && !host_we_n && !host_dq_oe)); // R3
  AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    host_dq_oe |-> (!host_ce_n && host_we_n && !host_oe_n && !wr_blocked)); // R2
  AST_FORCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    force_pulse |=> !force_pulse); // R7
  AST_FORCE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    force_pulse |-> wr_blocked); // R7
  AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    backup_armed |=> backup_armed); // R10
endmodule

bind pfwp_ctrl pfwp_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/pfwp_ctrl_bench.sv
module pfwp_ctrl_bench;
  localparam int CLK_HZ = 200_000_000;
  localparam int G_US = 1;
  localparam int R_US = 4;
  localparam int G = CLK_HZ / 1_000_000 * G_US;
  localparam int R = CLK_HZ / 1_000_000 * R_US;
  localparam int AW = 20;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok_a = 1'b1;
  logic host_ce_n = 1'b1, host_we_n = 1'b1, host_oe_n = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] mem_rdata = 8'h5A;
  logic [DW-1:0] host_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic host_dq_oe, mem_ce_n, mem_we_n, mem_oe_n, wr_blocked, force_pulse, backup_armed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfwp_ctrl #(.CLK_HZ(CLK_HZ), .GRACE_US(G_US), .RECOV_US(R_US), .AW(AW), .DW(DW)) u_pfwp_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok_a(supply_ok_a),
    .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_dq_oe(host_dq_oe),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .wr_blocked(wr_blocked), .force_pulse(force_pulse), .backup_armed(backup_armed));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host(input bit ce, input bit we, input bit oe);
    host_ce_n = ce; host_we_n = we; host_oe_n = oe;
  endtask

  task automatic t_reset_and_powerup;
    tick(3);
    chk(wr_blocked == 1'b1, "R11 blocked in reset", wr_blocked, 1);
    chk(backup_armed == 1'b0, "R10 armed clear in reset", backup_armed, 0);
    rst_n = 1'b1;
    tick(2);
    chk(backup_armed == 1'b0, "R10 armed before third edge", backup_armed, 0);
    tick(1);
    chk(backup_armed == 1'b1, "R10 armed on third edge", backup_armed, 1);
    tick(R - 1);
    chk(wr_blocked == 1'b1, "R9 still recovering", wr_blocked, 1);
    tick(1);
    chk(wr_blocked == 1'b0, "R9 recovery ends", wr_blocked, 0);
  endtask

  task automatic t_normal_ops;
    host_addr = 20'hABCDE; host_wdata = 8'h3C;
    host(1'b0, 1'b1, 1'b0);
    #1;
    chk(mem_ce_n == 0 && mem_oe_n == 0 && mem_we_n == 1, "R1 control pass", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b010);
    chk(mem_addr == 20'hABCDE && mem_wdata == 8'h3C, "R1 addr data pass", mem_addr, 20'hABCDE);
    tick(1);
    chk(host_dq_oe == 1 && host_rdata == 8'h5A, "R2 read drives", host_rdata, 8'h5A);
    host(1'b0, 1'b0, 1'b0);
    #1;
    chk(mem_we_n == 0 && host_dq_oe == 0, "R3 write with OE low", {mem_we_n, host_dq_oe}, 2'b00);
    tick(1);
    host(1'b0, 1'b1, 1'b0);
    #1;
    chk(host_dq_oe == 1, "R4 CE-first read resumes", host_dq_oe, 1);
    host(1'b0, 1'b1, 1'b1);
    #1;
    chk(host_dq_oe == 0 && host_rdata == 0, "R2 output disable", host_rdata, 0);
    host(1'b1, 1'b1, 1'b0);
    #1;
    chk(host_dq_oe == 0 && mem_ce_n == 1, "R2 deselected hiZ", host_dq_oe, 0);
    tick(1);
  endtask

  task automatic t_we_first;
    host(1'b1, 1'b0, 1'b0);
    tick(1);
    host(1'b0, 1'b0, 1'b0);
    tick(1);
    host(1'b0, 1'b1, 1'b0);
    #1;
    chk(host_dq_oe == 0, "R4 WE-first stays hiZ", host_dq_oe, 0);
    tick(2);
    chk(host_dq_oe == 0, "R4 WE-first later cycle", host_dq_oe, 0);
    host(1'b1, 1'b1, 1'b1);
    tick(1);
    host(1'b0, 1'b0, 1'b1);
    tick(1);
    host(1'b0, 1'b1, 1'b0);
    #1;
    chk(host_dq_oe == 0, "R4 simultaneous fall hiZ", host_dq_oe, 0);
    host(1'b1, 1'b1, 1'b1);
    tick(1);
  endtask

  task automatic t_recover;
    supply_ok_a = 1'b1;
    tick(3 + R);
    chk(wr_blocked == 0, "R9 back to normal", wr_blocked, 0);
  endtask

  task automatic t_idle_drop;
    host(1'b1, 1'b1, 1'b1);
    supply_ok_a = 1'b0;
    tick(2);
    chk(wr_blocked == 0, "R5 two-edge latency", wr_blocked, 0);
    tick(1);
    chk(wr_blocked == 1, "R5 protect on third edge", wr_blocked, 1);
    host_addr = 20'h12345;
    host(1'b0, 1'b0, 1'b0);
    #1;
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_addr == 0 && mem_wdata == 0 && !host_dq_oe,
        "R8 inputs ignored", {mem_ce_n, mem_we_n, mem_oe_n, host_dq_oe}, 4'b1110);
    host(1'b1, 1'b1, 1'b1);
    chk(backup_armed == 1, "R10 armed survives drop", backup_armed, 1);
    t_recover();
  endtask

  task automatic t_grace_complete;
    bit seen = 1'b0;
    host(1'b0, 1'b1, 1'b0);
    tick(1);
    supply_ok_a = 1'b0;
    tick(5);
    chk(mem_ce_n == 0 && wr_blocked == 0, "R6 cycle continues", mem_ce_n, 0);
    host(1'b1, 1'b1, 1'b1);
    tick(1);
    chk(wr_blocked == 1, "R6 protect after cycle end", wr_blocked, 1);
    for (int i = 0; i < G + 4; i++) begin
      if (force_pulse) seen = 1'b1;
      tick(1);
    end
    chk(!seen, "R6 no forced pulse", seen, 0);
    t_recover();
  endtask

  task automatic t_grace_timeout;
    host(1'b0, 1'b1, 1'b0);
    tick(1);
    supply_ok_a = 1'b0;
    tick(G + 2);
    chk(mem_ce_n == 0 && force_pulse == 0, "R7 grace still open", mem_ce_n, 0);
    tick(1);
    chk(mem_ce_n == 1 && force_pulse == 1 && wr_blocked == 1, "R7 forced protect",
        {mem_ce_n, force_pulse, wr_blocked}, 3'b111);
    tick(1);
    chk(force_pulse == 0, "R7 single pulse", force_pulse, 0);
    host(1'b1, 1'b1, 1'b1);
    t_recover();
  endtask

  task automatic t_recovery_restart;
    supply_ok_a = 1'b0;
    tick(4);
    supply_ok_a = 1'b1;
    tick(3 + R / 2);
    supply_ok_a = 1'b0;
    tick(2);
    supply_ok_a = 1'b1;
    tick(R / 2 + 4);
    chk(wr_blocked == 1, "R9 restarted count", wr_blocked, 1);
    tick(R - R / 2 - 2);
    chk(wr_blocked == 1, "R9 one before end", wr_blocked, 1);
    tick(1);
    chk(wr_blocked == 0, "R9 restart ends", wr_blocked, 0);
  endtask

  initial begin
    t_reset_and_powerup();
    t_normal_ops();
    t_we_first();
    t_idle_drop();
    t_grace_complete();
    t_grace_timeout();
    t_recovery_restart();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150_000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule